// File: doc/BRIEF.md
# Carrier-Gated Data Output Stage

This block sits behind a 1200 bps FSK demodulator that supplies a sliced bit and a raw in-band energy flag. From these it derives a carrier-detect output (low when active) that tolerates short gaps in the energy flag. It also drives two data outputs. The raw output shows every demodulated bit while the carrier is held valid. The validated output stays at mark until a preamble check has passed, so the alternating preamble never reaches it.

Carrier timing is counted on a one-millisecond strobe. Data bits are taken only on a bit-sample strobe. A mark is logic 1 and a space is logic 0. The preamble check works on sampled bits only. First it needs a long run in which every bit differs from the one before it, which arms the check. It then needs an unbroken run of marks. Losing the carrier discards all check state.

Top module: `carrier_data_gate`

## Requirements
- R1: While reset is applied, and on release from reset, `cd_n_o`, `raw_o` and `valid_o` are all 1.
- R2: With the carrier inactive, an acquisition count advances on each `ms_tick_i` cycle that has `energy_i` high. Any cycle with `energy_i` low clears the count. `cd_n_o` falls on the clock edge that samples the ACQ_MS-th counted tick (default 14).
- R3: With the carrier active, a gap count advances on each `ms_tick_i` cycle that has `energy_i` low. Any cycle with `energy_i` high clears the count. `cd_n_o` rises on the edge of the HOLD_MS-th counted tick (default 8), so gaps shorter than that are bridged.
- R4: `raw_o` equals `demod_bit_i` in the same cycle while `cd_n_o` is 0, and is 1 while `cd_n_o` is 1.
- R5: Bits are sampled on `bit_stb_i` while the carrier is active. The alternating run length is 1 for the first bit and for any bit equal to the bit before it, and otherwise grows by one, saturating at ALT_BITS (default 16). When the length reaches ALT_BITS, the check is armed.
- R6: While armed, the check passes on the strobe that makes the run of consecutive sampled 1 bits MARK_BITS long (default 10). That run may start with the last bit of the alternating run. From the next cycle, `valid_o` equals `demod_bit_i` while `cd_n_o` is 0. Before the pass, `valid_o` is 1.
- R7: A sampled 0 that leaves the alternating run length below ALT_BITS disarms the check. This happens on two 0s in a row, or on a 0 after two or more 1s.
- R8: While `cd_n_o` is 1, `valid_o` is 1. From the first inactive cycle, the armed and passed states are cleared, so a new carrier needs a full new preamble.
- R9: `demod_bit_i` values in cycles without `bit_stb_i`, and bits after a pass, do not change the check state. They are seen only through `raw_o` and `valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ms_tick_i | input | 1 | One-cycle strobe once per millisecond |
| bit_stb_i | input | 1 | One-cycle strobe at the bit sampling point |
| demod_bit_i | input | 1 | Demodulated bit, 1 = mark |
| energy_i | input | 1 | Raw carrier energy present |
| cd_n_o | output | 1 | Carrier detect, 0 = carrier valid |
| raw_o | output | 1 | Raw data, forced to 1 without carrier |
| valid_o | output | 1 | Validated data, 1 until the preamble check passes |

## Verification
Bursts are driven with preambles long enough to arm the check and with preambles too short to arm it. Some are followed by mark runs of adequate length and some by short ones. Comparing these separates the arming rule from the mark-count rule. Energy dropouts of a few ticks, dropouts of the full hold length, and flicker during acquisition separate bridging from release and from an acquisition restart. The demodulated bit is also toggled randomly between strobes, which exposes any sampling outside the strobe on the data outputs.

// File: rtl/carrier_data_gate.sv
module carrier_data_gate #(
  parameter int ACQ_MS    = 14,
  parameter int HOLD_MS   = 8,
  parameter int ALT_BITS  = 16,
  parameter int MARK_BITS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ms_tick_i,
  input  logic bit_stb_i,
  input  logic demod_bit_i,
  input  logic energy_i,
  output logic cd_n_o,
  output logic raw_o,
  output logic valid_o
);
  localparam int AW = $clog2(ACQ_MS + 1);
  localparam int HW = $clog2(HOLD_MS + 1);
  localparam int LW = $clog2(ALT_BITS + 1);
  localparam int MW = $clog2(MARK_BITS + 1);

  logic          carrier_q;
  logic [AW-1:0] acq_q;
  logic [HW-1:0] gap_q;
  logic [LW-1:0] alt_q, alt_nx;
  logic [MW-1:0] ones_q, ones_nx;
  logic          prev_q, armed_q, armed_nx, pass_q, pass_nx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carrier_q <= 1'b0;
      acq_q     <= '0;
      gap_q     <= '0;
    end else if (!carrier_q) begin
      gap_q <= '0;
      if (!energy_i) acq_q <= '0;
      else if (ms_tick_i) begin
        if (acq_q == AW'(ACQ_MS - 1)) begin
          carrier_q <= 1'b1;
          acq_q     <= '0;
        end else acq_q <= acq_q + 1'b1;
      end
    end else begin
      acq_q <= '0;
      if (energy_i) gap_q <= '0;
      else if (ms_tick_i) begin
        if (gap_q == HW'(HOLD_MS - 1)) begin
          carrier_q <= 1'b0;
          gap_q     <= '0;
        end else gap_q <= gap_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (alt_q == '0 || demod_bit_i == prev_q) alt_nx = LW'(1);
    else if (alt_q == LW'(ALT_BITS))          alt_nx = alt_q;
    else                                      alt_nx = alt_q + 1'b1;
    if (!demod_bit_i)                  ones_nx = '0;
    else if (ones_q == MW'(MARK_BITS)) ones_nx = ones_q;
    else                               ones_nx = ones_q + 1'b1;
    armed_nx = (alt_nx == LW'(ALT_BITS)) || (demod_bit_i && armed_q);
    pass_nx  = armed_nx && (ones_nx == MW'(MARK_BITS));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alt_q <= '0; ones_q <= '0; prev_q <= 1'b0; armed_q <= 1'b0; pass_q <= 1'b0;
    end else if (!carrier_q) begin
      alt_q <= '0; ones_q <= '0; prev_q <= 1'b0; armed_q <= 1'b0; pass_q <= 1'b0;
    end else if (bit_stb_i && !pass_q) begin
      alt_q   <= alt_nx;
      ones_q  <= ones_nx;
      prev_q  <= demod_bit_i;
      armed_q <= armed_nx;
      pass_q  <= pass_nx;
    end
  end

  assign cd_n_o  = ~carrier_q;
  assign raw_o   = carrier_q ? demod_bit_i : 1'b1;
  assign valid_o = (carrier_q && pass_q) ? demod_bit_i : 1'b1;

  p_acq_on_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cd_n_o) |-> $past(energy_i && ms_tick_i));
  p_release_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cd_n_o) |-> $past(!energy_i && ms_tick_i));
  p_arm_before_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pass_q) |-> $past(armed_q));
  p_pass_on_mark_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pass_q) |-> $past(bit_stb_i && demod_bit_i));
  p_clear_on_loss_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cd_n_o) |=> (!pass_q && !armed_q));
  p_idle_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !cd_n_o);
  p_no_strobe_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_stb_i && carrier_q) |=> ($stable(alt_q) && $stable(ones_q) && $stable(pass_q)));
endmodule

// File: tb/carrier_data_gate_tb_top.sv
module carrier_data_gate_tb_top;
  localparam int ACQ = 14, HOLD = 8, ALT = 16, MARK = 10;
  localparam int TICK = 16, BITP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ms_tick = 1'b0, bit_stb = 1'b0, demod = 1'b1, energy = 1'b0;
  logic cd_n, raw, valid;
  int vectors = 0, miscompares = 0, tcnt = 0, wd = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  carrier_data_gate #(.ACQ_MS(ACQ), .HOLD_MS(HOLD), .ALT_BITS(ALT), .MARK_BITS(MARK)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ms_tick_i(ms_tick), .bit_stb_i(bit_stb),
    .demod_bit_i(demod), .energy_i(energy), .cd_n_o(cd_n), .raw_o(raw), .valid_o(valid));

  // reference model built from R2, R3, R5-R9
  bit m_car, m_prev, m_armed, m_pass;
  int m_acq, m_gap, m_alt, m_ones;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_car = 0; m_acq = 0; m_gap = 0; m_alt = 0; m_ones = 0;
      m_prev = 0; m_armed = 0; m_pass = 0;
    end else begin
      if (!m_car) begin
        m_alt = 0; m_ones = 0; m_prev = 0; m_armed = 0; m_pass = 0;
      end else if (bit_stb && !m_pass) begin
        m_alt  = (m_alt == 0 || demod == m_prev) ? 1 : (m_alt < ALT ? m_alt + 1 : ALT);
        m_ones = demod ? (m_ones < MARK ? m_ones + 1 : MARK) : 0;
        m_armed = (m_alt == ALT) || (demod && m_armed);
        m_pass = m_armed && (m_ones == MARK);
        m_prev = demod;
      end
      if (!m_car) begin
        m_gap = 0;
        if (!energy) m_acq = 0;
        else if (ms_tick) begin
          m_acq++;
          if (m_acq == ACQ) begin m_car = 1; m_acq = 0; end
        end
      end else begin
        m_acq = 0;
        if (energy) m_gap = 0;
        else if (ms_tick) begin
          m_gap++;
          if (m_gap == HOLD) begin m_car = 0; m_gap = 0; end
        end
      end
    end
  end

  function automatic logic exp_raw();
    return m_car ? demod : 1'b1;
  endfunction
  function automatic logic exp_valid();
    return (m_car && m_pass) ? demod : 1'b1;
  endfunction

  task automatic cmp(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic check_all();
    cmp("R2/R3 cd_n", cd_n, ~m_car);
    cmp("R4 raw", raw, exp_raw());
    cmp("R5/R6/R7/R8/R9 valid", valid, exp_valid());
  endtask

  function automatic logic script_bit(int idx, int alt_n, bit start, int mark_n);
    if (idx < alt_n) return start ^ idx[0];
    if (idx < alt_n + mark_n) return 1'b1;
    return 1'($urandom_range(0, 1));
  endfunction

  // one energy burst; drop window gives dropouts (R3) or acquisition flicker (R2)
  task automatic burst(int on_cyc, int alt_n, bit start, int mark_n, int drop_at, int drop_len);
    int idx = 0;
    for (int c = 0; c < on_cyc; c++) begin
      @(negedge clk);
      check_all();
      tcnt++;
      ms_tick = (tcnt % TICK == 0);
      bit_stb = (tcnt % BITP == 0);
      energy  = !(c >= drop_at && c < drop_at + drop_len);
      if (bit_stb) begin
        demod = m_car ? script_bit(idx, alt_n, start, mark_n) : 1'($urandom_range(0, 1));
        if (m_car) idx++;
      end else demod = 1'($urandom_range(0, 1)); // R9: noise between strobes
    end
  endtask

  task automatic idle(int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      check_all();
      tcnt++;
      ms_tick = (tcnt % TICK == 0);
      bit_stb = (tcnt % BITP == 0);
      energy  = 1'b0;
      demod   = 1'($urandom_range(0, 1));
    end
  endtask

  localparam int ACQC = (ACQ + 1) * TICK;

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    cmp("R1 cd_n", cd_n, 1'b1);
    cmp("R1 raw", raw, 1'b1);
    cmp("R1 valid", valid, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 cd_n", cd_n, 1'b1);
    cmp("R1 valid", valid, 1'b1);
    // R6 normal preamble and marks
    burst(ACQC + 60 * BITP * 2, 20, 0, 12, 1 << 30, 0);
    idle((HOLD + 2) * TICK);
    // R5 alternation too short
    burst(ACQC + 50 * BITP * 2, 12, 1, 14, 1 << 30, 0);
    idle((HOLD + 2) * TICK);
    // R6 mark run too short
    burst(ACQC + 50 * BITP * 2, 20, 1, 8, 1 << 30, 0);
    idle((HOLD + 2) * TICK);
    // R3 dropout shorter than hold is bridged
    burst(ACQC + 400, 18, 0, 11, ACQC + 100, 5 * TICK);
    idle((HOLD + 2) * TICK);
    // R3 dropout of full hold releases, R8 then a new preamble is needed
    burst(ACQC + 900, 18, 0, 11, ACQC + 250, (HOLD + 1) * TICK);
    idle((HOLD + 2) * TICK);
    // R2 flicker during acquisition restarts the count
    burst(ACQC + 600, 17, 1, 10, 5 * TICK, 2);
    idle((HOLD + 2) * TICK);
    // R7 preamble broken by a repeated bit after arming is covered by random data below
    for (int b = 0; b < 24; b++) begin
      int dlen = $urandom_range(0, 1) ? $urandom_range(1, 10) * TICK : 0;
      burst(ACQC + $urandom_range(200, 700), $urandom_range(6, 24), 1'($urandom_range(0, 1)),
            $urandom_range(4, 14), ACQC + $urandom_range(0, 300), dlen);
      idle($urandom_range(HOLD, HOLD + 4) * TICK);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 190000 && !done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog actual=%0d expected<190000 cycles", wd);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule